// File: doc/BRIEF.md
# HDB3 Receive Line-Code Violation Detector

This block watches a dual-rail received line signal, one symbol for each strobe from clock recovery, and reports line-code errors on a single registered error pulse. It keeps the polarity of the most recent mark. A mark with the same polarity as the mark before it is a bipolar violation. It also keeps the polarity of the most recent bipolar violation, so that two violations in a row with the same polarity show up as an HDB3 code violation. A run of zeros that correct HDB3 encoding can never produce is reported as a zero-substitution violation.

Each of the three error classes has its own enable, and the enabled classes merge onto one output. Code-violation and zero-violation reporting also require the HDB3/E1 mode flag, because both rules only have meaning for HDB3-coded data. The receiver front end places the block after its rail slicers. A counter or alarm stage downstream consumes the pulse.

Top module: `hdb3_viol_detect`

## Requirements
- R1: After reset `errPulse` is low, and the first mark received after reset never produces a bipolar violation.
- R2: Rail encoding is: posRail=1/negRail=0 is a positive mark, posRail=0/negRail=1 is a negative mark, both low is a zero. With `enBpv` high, a mark with the same polarity as the previous polarized mark raises `errPulse` in the cycle after the symbol is taken.
- R3: Marks that alternate in polarity never produce an error.
- R4: With `hdb3Mode` and `enCodeV` high, a bipolar violation with the same polarity as the previous bipolar violation raises `errPulse`. A violation with the opposite polarity does not.
- R5: The first bipolar violation after reset never produces a code violation.
- R6: With `hdb3Mode` and `enZeroV` high, the 4th consecutive zero raises `errPulse` once. Further zeros in the same run do not. Any mark re-arms the detector.
- R7: With `hdb3Mode` low, code violations and zero violations never raise `errPulse`.
- R8: A symbol with both rails high is a mark of neither polarity. It clears the zero run, leaves the mark-polarity history unchanged, and is never a violation itself.
- R9: Each class reports only while its own enable is high. With all enables low, `errPulse` stays low.
- R10: A cycle with `symValid` low is ignored: no pulse results from it, and no history or zero-run state changes.
- R11: Each report is exactly one cycle wide. Several classes detected in the same symbol produce a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | A line symbol is present this cycle |
| posRail | input | 1 | Positive rail of the received symbol |
| negRail | input | 1 | Negative rail of the received symbol |
| hdb3Mode | input | 1 | HDB3/E1 decoding active |
| enBpv | input | 1 | Enable bipolar-violation reports |
| enCodeV | input | 1 | Enable code-violation reports |
| enZeroV | input | 1 | Enable zero-run violation reports |
| errPulse | output | 1 | Registered one-cycle error report |

## Verification
The bench targets the history corners. An ignored symbol or a both-rails-high symbol that wrongly updated the mark polarity would move a bipolar violation by one mark, or hide it. A code-violation detector that kept no cleared state at reset would fire on the first violation. A zero-run counter that did not saturate, or that a both-high symbol did not clear, would pulse repeatedly or on the wrong zero. A missing mode gate or enable gate shows up as a pulse where none is expected. Classes that coincide in one symbol must still give one pulse, followed by a low cycle.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  // Strobes from control to datapath, valid for one symbol
  typedef struct packed {
    logic updMark;  // store markPol as the latest mark polarity
    logic markPol;  // 1 = positive
    logic updViol;  // store markPol as the latest violation polarity
    logic clrZero;  // clear the zero-run counter
    logic incZero;  // advance the zero-run counter
  } hdb3Strobe_t;
endpackage

// File: rtl/hdb3_datapath.sv
module hdb3_datapath
  import hdb3_pkg::*;
#(
  parameter int ZERO_RUN = 4,
  localparam int CNT_W = $clog2(ZERO_RUN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hdb3Strobe_t      stb,
  input  logic             symValid,
  input  logic             posRail,
  input  logic             negRail,
  output logic             haveMark,
  output logic             lastMarkPol,
  output logic             haveViol,
  output logic             lastViolPol,
  output logic [CNT_W-1:0] zeroCnt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveMark    <= 1'b0;
      lastMarkPol <= 1'b0;
      haveViol    <= 1'b0;
      lastViolPol <= 1'b0;
      zeroCnt     <= '0;
    end else begin
      if (stb.updMark) begin
        haveMark    <= 1'b1;
        lastMarkPol <= stb.markPol;
      end
      if (stb.updViol) begin
        haveViol    <= 1'b1;
        lastViolPol <= stb.markPol;
      end
      if (stb.clrZero)      zeroCnt <= '0;
      else if (stb.incZero) zeroCnt <= zeroCnt + 1'b1;
    end
  end

  // R6: the counter never runs past the run length
  a_r6_zero_saturate: assert property (@(posedge clk) disable iff (!rstN)
    zeroCnt <= CNT_W'(ZERO_RUN));

  // R8: a both-rails-high symbol leaves the zero run empty
  a_r8_both_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(symValid && posRail && negRail) |-> zeroCnt == '0);

  // R10: idle cycles leave the history untouched
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(symValid) |-> ($stable(lastMarkPol) && $stable(haveMark)
                          && $stable(lastViolPol) && $stable(zeroCnt)));

endmodule

// File: rtl/hdb3_ctrl.sv
module hdb3_ctrl
  import hdb3_pkg::*;
#(
  parameter int ZERO_RUN = 4,
  localparam int CNT_W = $clog2(ZERO_RUN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic             posRail,
  input  logic             negRail,
  input  logic             hdb3Mode,
  input  logic             enBpv,
  input  logic             enCodeV,
  input  logic             enZeroV,
  input  logic             haveMark,
  input  logic             lastMarkPol,
  input  logic             haveViol,
  input  logic             lastViolPol,
  input  logic [CNT_W-1:0] zeroCnt,
  output hdb3Strobe_t      stb,
  output logic             errPulse
);

  logic polMark, anyMark, isZero;
  logic bpvHit, codeHit, zeroHit, errNext;

  always_comb begin
    polMark = symValid && (posRail ^ negRail);
    anyMark = symValid && (posRail || negRail);
    isZero  = symValid && !posRail && !negRail;

    bpvHit  = polMark && haveMark && (posRail == lastMarkPol);
    codeHit = bpvHit && haveViol && (posRail == lastViolPol);
    zeroHit = isZero && (zeroCnt == CNT_W'(ZERO_RUN - 1));

    stb.updMark = polMark;
    stb.markPol = posRail;
    stb.updViol = bpvHit;
    stb.clrZero = anyMark;
    stb.incZero = isZero && (zeroCnt < CNT_W'(ZERO_RUN));

    errNext = (bpvHit && enBpv)
            || (codeHit && enCodeV && hdb3Mode)
            || (zeroHit && enZeroV && hdb3Mode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= errNext;
  end

  // R10: a report always traces back to a taken symbol
  a_r10_needs_symbol: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(symValid));

  // R7: without the bipolar enable, only HDB3 mode can report
  a_r7_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !$past(enBpv)) |-> $past(hdb3Mode));

  // R9: all classes disabled means silence
  a_r9_all_off: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enBpv || enCodeV || enZeroV) |-> !errPulse);

  // R8: a both-high symbol is never itself a violation
  a_r8_both_silent: assert property (@(posedge clk) disable iff (!rstN)
    $past(symValid && posRail && negRail) |-> !errPulse);

endmodule

// File: rtl/hdb3_viol_detect.sv
module hdb3_viol_detect
  import hdb3_pkg::*;
#(
  parameter int ZERO_RUN = 4,
  localparam int CNT_W = $clog2(ZERO_RUN + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic symValid,
  input  logic posRail,
  input  logic negRail,
  input  logic hdb3Mode,
  input  logic enBpv,
  input  logic enCodeV,
  input  logic enZeroV,
  output logic errPulse
);

  hdb3Strobe_t      stb;
  logic             haveMark, lastMarkPol, haveViol, lastViolPol;
  logic [CNT_W-1:0] zeroCnt;

  hdb3_ctrl #(.ZERO_RUN(ZERO_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .posRail(posRail),
    .negRail(negRail), .hdb3Mode(hdb3Mode), .enBpv(enBpv),
    .enCodeV(enCodeV), .enZeroV(enZeroV), .haveMark(haveMark),
    .lastMarkPol(lastMarkPol), .haveViol(haveViol),
    .lastViolPol(lastViolPol), .zeroCnt(zeroCnt), .stb(stb),
    .errPulse(errPulse)
  );

  hdb3_datapath #(.ZERO_RUN(ZERO_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .symValid(symValid),
    .posRail(posRail), .negRail(negRail), .haveMark(haveMark),
    .lastMarkPol(lastMarkPol), .haveViol(haveViol),
    .lastViolPol(lastViolPol), .zeroCnt(zeroCnt)
  );

endmodule

// File: tb/hdb3_viol_detect_tb.sv
module hdb3_viol_detect_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0, posRail = 1'b0, negRail = 1'b0;
  logic hdb3Mode = 1'b0, enBpv = 1'b0, enCodeV = 1'b0, enZeroV = 1'b0;
  logic errPulse;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hdb3_viol_detect u_dut (
    .clk(clk), .rstN(rstN), .symValid(symValid), .posRail(posRail),
    .negRail(negRail), .hdb3Mode(hdb3Mode), .enBpv(enBpv),
    .enCodeV(enCodeV), .enZeroV(enZeroV), .errPulse(errPulse)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (errPulse !== exp) begin
      errors++;
      $display("FAIL %s: errPulse=%b expected %b at %0t", tag, errPulse, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, sample just after the next rising edge
  task automatic sym(input logic v, input logic p, input logic n,
                     input logic exp, input string tag);
    @(negedge clk);
    symValid = v; posRail = p; negRail = n;
    @(posedge clk);
    #1 check(exp, tag);
  endtask

  task automatic doReset(input logic m, input logic eb, input logic ec, input logic ez);
    @(negedge clk);
    rstN = 1'b0; symValid = 1'b0; posRail = 1'b0; negRail = 1'b0;
    hdb3Mode = m; enBpv = eb; enCodeV = ec; enZeroV = ez;
    @(posedge clk); @(posedge clk);
    #1 check(1'b0, "R1 reset");
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tBpv();
    doReset(1, 1, 0, 0);
    sym(1, 1, 0, 0, "R1 first mark");
    sym(1, 0, 1, 0, "R3 alt");
    sym(1, 1, 0, 0, "R3 alt");
    sym(1, 1, 0, 1, "R2 bpv pos");
    sym(1, 0, 0, 0, "R11 one cycle");
    sym(1, 0, 1, 0, "R3 alt after zero");
    sym(1, 0, 1, 1, "R2 bpv neg");
  endtask

  task automatic tCode();
    doReset(1, 0, 1, 0);
    sym(1, 1, 0, 0, "R4 setup");
    sym(1, 1, 0, 0, "R5 first violation");
    sym(1, 1, 0, 1, "R4 same polarity");
    sym(1, 0, 1, 0, "R4 alt");
    sym(1, 0, 1, 0, "R4 opposite polarity");
    sym(1, 0, 1, 1, "R4 same neg");
  endtask

  task automatic tZero();
    doReset(1, 0, 0, 1);
    sym(1, 1, 0, 0, "R6 mark");
    for (int i = 0; i < 3; i++) sym(1, 0, 0, 0, "R6 zeros 1-3");
    sym(1, 0, 0, 1, "R6 fourth zero");
    for (int i = 0; i < 6; i++) sym(1, 0, 0, 0, "R6 saturated");
    sym(1, 0, 1, 0, "R6 rearm mark");
    for (int i = 0; i < 3; i++) sym(1, 0, 0, 0, "R6 zeros again");
    sym(1, 0, 0, 1, "R6 fourth zero again");
  endtask

  task automatic tMode();
    doReset(0, 0, 1, 1);
    sym(1, 1, 0, 0, "R7 mark");
    sym(1, 1, 0, 0, "R7 viol");
    sym(1, 1, 0, 0, "R7 code viol masked");
    for (int i = 0; i < 5; i++) sym(1, 0, 0, 0, "R7 zero run masked");
  endtask

  task automatic tBoth();
    doReset(1, 1, 0, 1);
    for (int i = 0; i < 3; i++) sym(1, 0, 0, 0, "R8 zeros");
    sym(1, 1, 1, 0, "R8 both high silent");
    for (int i = 0; i < 3; i++) sym(1, 0, 0, 0, "R8 run restarted");
    sym(1, 0, 0, 1, "R8 fourth zero after clear");
    sym(1, 1, 0, 0, "R8 mark");
    sym(1, 1, 1, 0, "R8 both");
    sym(1, 0, 1, 0, "R8 history kept, alt");
    sym(1, 1, 1, 0, "R8 both");
    sym(1, 0, 1, 1, "R8 history kept, bpv");
  endtask

  task automatic tEnables();
    doReset(1, 0, 0, 0);
    sym(1, 1, 0, 0, "R9 mark");
    sym(1, 1, 0, 0, "R9 bpv disabled");
    sym(1, 1, 0, 0, "R9 code disabled");
    for (int i = 0; i < 4; i++) sym(1, 0, 0, 0, "R9 zero disabled");
  endtask

  task automatic tIdle();
    doReset(1, 1, 0, 1);
    sym(1, 1, 0, 0, "R10 mark");
    sym(0, 0, 1, 0, "R10 idle neg");
    sym(1, 1, 0, 1, "R10 history unchanged");
    sym(1, 0, 0, 0, "R10 zero 1");
    sym(1, 0, 0, 0, "R10 zero 2");
    sym(0, 0, 0, 0, "R10 idle zero");
    sym(0, 0, 0, 0, "R10 idle zero");
    sym(1, 0, 0, 0, "R10 zero 3");
    sym(1, 0, 0, 1, "R10 zero 4");
  endtask

  task automatic tMerge();
    doReset(1, 1, 1, 0);
    sym(1, 1, 0, 0, "R11 mark");
    sym(1, 1, 0, 1, "R11 bpv");
    sym(1, 1, 0, 1, "R11 bpv+code merged");
    sym(1, 0, 0, 0, "R11 single cycle");
  endtask

  initial begin
    tBpv();
    tCode();
    tZero();
    tMode();
    tBoth();
    tEnables();
    tIdle();
    tMerge();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule